// File: doc/BRIEF.md
# GPIO Bank Interrupt and Wake Detector

This block turns the filtered input levels of a GPIO bank into interrupt and wake requests. Each pin can be set to report a rising edge, a falling edge, either edge, or a level of chosen polarity. Every detected event is held in a sticky status bit until software writes a 1 to that bit. A per-pin mask decides which held events reach the single interrupt output. Alongside this, a wake path keeps its own status bit per pin. That bit is set by the same events, but only for pins whose wake-mask bit is 1. Any set wake bit drives the wake output.

The block receives word-wide register writes and reads. Each register kind has a fixed base address, and the word that covers pins 32w to 32w+31 sits at base + 4w. The bank width is a parameter and must be a multiple of 32, up to 192 pins. Pad synchronisation and glitch filtering happen upstream of the block, and the CPU interrupt controller sits downstream of it.

Top module: `gpio_irq_wake`

## Requirements
- R1: With a pin in edge mode (type bit 0) and its rising enable bit set, a 0-to-1 change on the pin sets its interrupt status bit at the clock edge that first samples the new level. The pin level is captured during reset, so a pin held high through reset raises no event.
- R2: With the falling enable bit set, a 1-to-0 change sets the status bit. With only the falling enable set, a rising change sets nothing. With both enables set, either change sets the bit.
- R3: With the type bit at 1 (level mode), the status bit is set on every clock while the pin sits at its active level, whatever the edge enables say. The polarity bit picks the active level: 1 means active low and 0 means active high.
- R4: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged, in that word only. In level mode the bit is set again at once for as long as the level stays active.
- R5: Status bits latch whatever the mask says. `irq_out` is 1 exactly when some status bit and its mask bit are both 1.
- R6: If an event and a write-1-to-clear land on the same bit in the same cycle, the bit stays set.
- R7: A wake status bit is set by the pin's event only when that pin's wake-mask bit is 1. It is cleared by writing 1 to it. `wake_out` is the OR of all wake status bits. Clearing wake status does not touch interrupt status.
- R8: After reset, every configuration and status register reads 0, and `irq_out` and `wake_out` are 0.
- R9: The register bases are: rising enable 0x064, falling enable 0x07C, mask 0x0AC, status 0x0C4, type 0x300, polarity 0x318, wake mask 0x400 and wake status 0x418. The word for pin group w sits at base + 4w. Reads of unmapped, misaligned or out-of-range addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Byte address of the combinational read |
| rd_data | output | 32 | Read data, 0 for unmapped addresses |
| pin_in | input | NUM_PINS | Filtered pin levels |
| irq_out | output | 1 | Combined masked interrupt |
| wake_out | output | 1 | Combined wake request |

## Verification
The bench builds the block with NUM_PINS = 64, so the bank has two register words per kind. This exercises the base + 4w decode for the second word and the rule that a status clear stays within one word. It also covers the out-of-range case: at this width, word 2 of a register kind is unmapped and must read as 0 and ignore writes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W  = 12;
    localparam int WORD_W  = 32;
    localparam int MAX_WORDS = 6;

    typedef enum logic [3:0] {
        SEL_NONE  = 4'd0,
        SEL_RISE  = 4'd1,
        SEL_FALL  = 4'd2,
        SEL_TYPE  = 4'd3,
        SEL_POL   = 4'd4,
        SEL_MASK  = 4'd5,
        SEL_STAT  = 4'd6,
        SEL_WMASK = 4'd7,
        SEL_WSTAT = 4'd8
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [2:0] word;
    } reg_dec_t;

    function automatic logic [ADDR_W-1:0] base_of(input reg_sel_e s);
        case (s)
            SEL_RISE:  return 12'h064;
            SEL_FALL:  return 12'h07C;
            SEL_MASK:  return 12'h0AC;
            SEL_STAT:  return 12'h0C4;
            SEL_TYPE:  return 12'h300;
            SEL_POL:   return 12'h318;
            SEL_WMASK: return 12'h400;
            SEL_WSTAT: return 12'h418;
            default:   return 12'hFFF;
        endcase
    endfunction

    // Map a byte address to a register kind and word index.
    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] addr,
                                             input int nwords);
        reg_dec_t d;
        logic [ADDR_W:0] lo;
        logic [ADDR_W:0] hi;
        logic [ADDR_W:0] diff;
        d.sel  = SEL_NONE;
        d.word = '0;
        for (int k = 1; k <= 8; k++) begin
            lo   = {1'b0, base_of(reg_sel_e'(k))};
            hi   = lo + 13'(4 * nwords);
            diff = {1'b0, addr} - lo;
            if (addr[1:0] == 2'b00 && {1'b0, addr} >= lo && {1'b0, addr} < hi) begin
                d.sel  = reg_sel_e'(k);
                d.word = diff[4:2];
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    localparam int NUM_WORDS = NUM_PINS / WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  reg_sel_e             wr_sel,
    input  logic [NUM_WORDS-1:0] wr_word_oh,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [NUM_PINS-1:0]  rise_en,
    output logic [NUM_PINS-1:0]  fall_en,
    output logic [NUM_PINS-1:0]  lvl_mode,
    output logic [NUM_PINS-1:0]  act_low,
    output logic [NUM_PINS-1:0]  irq_mask,
    output logic [NUM_PINS-1:0]  wake_mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_en   <= '0;
            fall_en   <= '0;
            lvl_mode  <= '0;
            act_low   <= '0;
            irq_mask  <= '0;
            wake_mask <= '0;
        end else begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (wr_word_oh[w]) begin
                    case (wr_sel)
                        SEL_RISE:  rise_en[w*WORD_W +: WORD_W]   <= wr_data;
                        SEL_FALL:  fall_en[w*WORD_W +: WORD_W]   <= wr_data;
                        SEL_TYPE:  lvl_mode[w*WORD_W +: WORD_W]  <= wr_data;
                        SEL_POL:   act_low[w*WORD_W +: WORD_W]   <= wr_data;
                        SEL_MASK:  irq_mask[w*WORD_W +: WORD_W]  <= wr_data;
                        SEL_WMASK: wake_mask[w*WORD_W +: WORD_W] <= wr_data;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R8: edge enables come out of reset cleared
    assert_edge_en_reset_R8: assert property (@(posedge clk)
        $past(rst) |-> (rise_en == '0 && fall_en == '0));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] rise_en,
    input  logic [NUM_PINS-1:0] fall_en,
    input  logic [NUM_PINS-1:0] lvl_mode,
    input  logic [NUM_PINS-1:0] act_low,
    output logic [NUM_PINS-1:0] evt
);

    logic [NUM_PINS-1:0] pin_q;

    // Level captured in reset, so no edge appears across reset release (R1)
    always_ff @(posedge clk) begin
        pin_q <= pin_in;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic up, down, active;
        assign up     = pin_in[i] & ~pin_q[i];
        assign down   = ~pin_in[i] & pin_q[i];
        assign active = pin_in[i] ^ act_low[i];
        assign evt[i] = lvl_mode[i] ? active
                                    : ((rise_en[i] & up) | (fall_en[i] & down));
    end

    // R1 R2: in edge mode an event needs the sampled level to have moved
    assert_edge_needs_change_R2: assert property (@(posedge clk) disable iff (rst)
        ((evt & ~lvl_mode & ~(pin_in ^ pin_q)) == '0));

endmodule

// File: rtl/gpio_irq_sticky.sv
module gpio_irq_sticky #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] stat_q
);

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_i) | set_i;
    end

    // R4: a cleared bit with no competing event reads 0 afterwards
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat_q & $past(clr_i & ~set_i)) == '0));

    // R6: an event always wins over a simultaneous clear
    assert_event_wins_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(set_i) & ~stat_q) == '0));

endmodule

// File: rtl/gpio_irq_wake.sv
module gpio_irq_wake
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    localparam int NUM_WORDS = NUM_PINS / WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                irq_out,
    output logic                wake_out
);

    reg_dec_t wdec, rdec;
    assign wdec = decode_addr(wr_addr, NUM_WORDS);
    assign rdec = decode_addr(rd_addr, NUM_WORDS);

    logic [NUM_WORDS-1:0] wr_word_oh;
    logic [NUM_PINS-1:0]  irq_clr, wake_clr;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign wr_word_oh[w] = wr_en && (wdec.sel != SEL_NONE) && (wdec.word == 3'(w));
        assign irq_clr[w*WORD_W +: WORD_W] =
            (wr_word_oh[w] && wdec.sel == SEL_STAT) ? wr_data : '0;
        assign wake_clr[w*WORD_W +: WORD_W] =
            (wr_word_oh[w] && wdec.sel == SEL_WSTAT) ? wr_data : '0;
    end

    logic [NUM_PINS-1:0] rise_en, fall_en, lvl_mode, act_low, irq_mask, wake_mask;
    logic [NUM_PINS-1:0] evt, irq_stat, wake_stat;

    gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk(clk), .rst(rst), .wr_sel(wdec.sel), .wr_word_oh(wr_word_oh),
        .wr_data(wr_data), .rise_en(rise_en), .fall_en(fall_en),
        .lvl_mode(lvl_mode), .act_low(act_low), .irq_mask(irq_mask),
        .wake_mask(wake_mask)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk(clk), .rst(rst), .pin_in(pin_in), .rise_en(rise_en),
        .fall_en(fall_en), .lvl_mode(lvl_mode), .act_low(act_low), .evt(evt)
    );

    gpio_irq_sticky #(.WIDTH(NUM_PINS)) u_irq_stat (
        .clk(clk), .rst(rst), .set_i(evt), .clr_i(irq_clr), .stat_q(irq_stat)
    );

    gpio_irq_sticky #(.WIDTH(NUM_PINS)) u_wake_stat (
        .clk(clk), .rst(rst), .set_i(evt & wake_mask), .clr_i(wake_clr),
        .stat_q(wake_stat)
    );

    assign irq_out  = |(irq_stat & irq_mask);
    assign wake_out = |wake_stat;

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rdec.word == 3'(w)) begin
                case (rdec.sel)
                    SEL_RISE:  rd_data = rise_en[w*WORD_W +: WORD_W];
                    SEL_FALL:  rd_data = fall_en[w*WORD_W +: WORD_W];
                    SEL_TYPE:  rd_data = lvl_mode[w*WORD_W +: WORD_W];
                    SEL_POL:   rd_data = act_low[w*WORD_W +: WORD_W];
                    SEL_MASK:  rd_data = irq_mask[w*WORD_W +: WORD_W];
                    SEL_STAT:  rd_data = irq_stat[w*WORD_W +: WORD_W];
                    SEL_WMASK: rd_data = wake_mask[w*WORD_W +: WORD_W];
                    SEL_WSTAT: rd_data = wake_stat[w*WORD_W +: WORD_W];
                    default: ;
                endcase
            end
        end
    end

    // R5: the combined interrupt is never raised without a held event
    assert_irq_has_source_R5: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (irq_stat != '0));

    // R7: a wake bit can only newly appear on a pin whose wake mask was set
    assert_wake_gated_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((wake_stat & ~$past(wake_stat) & ~$past(wake_mask)) == '0));

    // R8: outputs quiet on the first cycle after reset
    assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_out && !wake_out));

endmodule

// File: tb/test_gpio_irq_wake.sv
module test_gpio_irq_wake;

    localparam int NP = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [NP-1:0] pins = '0;
    logic        irq_out, wake_out;

    int checks = 0;
    int fails  = 0;

    localparam logic [11:0] A_RISE = 12'h064, A_FALL = 12'h07C, A_MASK = 12'h0AC,
                            A_STAT = 12'h0C4, A_TYPE = 12'h300, A_POL = 12'h318,
                            A_WMSK = 12'h400, A_WSTA = 12'h418;

    always #5 clk = ~clk;

    gpio_irq_wake #(.NUM_PINS(NP)) i_gpio_irq_wake (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pins),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk);
        pins[i] = v;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        check("R8 irq_out", {31'd0, irq_out}, 32'd0);
        check("R8 wake_out", {31'd0, wake_out}, 32'd0);
        for (int w = 0; w < 2; w++) begin
            check_reg("R8 rise", A_RISE + 12'(4*w), 0);
            check_reg("R8 fall", A_FALL + 12'(4*w), 0);
            check_reg("R8 type", A_TYPE + 12'(4*w), 0);
            check_reg("R8 pol",  A_POL  + 12'(4*w), 0);
            check_reg("R8 mask", A_MASK + 12'(4*w), 0);
            check_reg("R8 stat", A_STAT + 12'(4*w), 0);
            check_reg("R8 wmask", A_WMSK + 12'(4*w), 0);
            check_reg("R8 wstat", A_WSTA + 12'(4*w), 0);
        end
    endtask

    task automatic t_rise();
        wr(A_RISE, 32'h8);
        @(posedge clk); #1;
        check_reg("R1 no event across reset", A_STAT, 0);
        set_pin(3, 1'b0);
        check_reg("R1 falling ignored", A_STAT, 0);
        set_pin(3, 1'b1);
        check_reg("R1 rising sets", A_STAT, 32'h8);
        wr(A_RISE + 12'd4, 32'h100);
        set_pin(40, 1'b1);
        check_reg("R9 word1 status", A_STAT + 12'd4, 32'h100);
        check_reg("R9 word1 rise readback", A_RISE + 12'd4, 32'h100);
        wr(A_STAT, 32'h8);
        check_reg("R4 clear word0", A_STAT, 0);
        check_reg("R4 other word kept", A_STAT + 12'd4, 32'h100);
        wr(A_STAT + 12'd4, 32'h100);
        check_reg("R4 clear word1", A_STAT + 12'd4, 0);
    endtask

    task automatic t_fall_both();
        wr(A_FALL, 32'h280);
        wr(A_RISE, 32'h88);
        set_pin(9, 1'b1);
        check_reg("R2 fall-only ignores rise", A_STAT, 0);
        set_pin(7, 1'b1);
        check_reg("R2 both: rise", A_STAT, 32'h80);
        wr(A_STAT, 32'h80);
        set_pin(7, 1'b0);
        check_reg("R2 both: fall", A_STAT, 32'h80);
        set_pin(9, 1'b0);
        check_reg("R2 fall sets", A_STAT, 32'h280);
    endtask

    task automatic t_mask();
        check("R5 unmasked status, irq low", {31'd0, irq_out}, 0);
        wr(A_MASK, 32'h80);
        check("R5 mask enables irq", {31'd0, irq_out}, 1);
        wr(A_MASK, 32'h10);
        check("R5 other mask, irq low", {31'd0, irq_out}, 0);
        wr(A_MASK, 32'h80);
        wr(A_STAT, 32'h280);
        check("R5 clear drops irq", {31'd0, irq_out}, 0);
        check_reg("R4 cleared", A_STAT, 0);
    endtask

    task automatic t_level();
        wr(A_POL, 32'h1000);
        wr(A_TYPE, 32'h1000);
        @(posedge clk); #1;
        check_reg("R3 active-low level sets", A_STAT, 32'h1000);
        wr(A_STAT, 32'h1000);
        check_reg("R4 clear blocked by active level", A_STAT, 32'h1000);
        set_pin(12, 1'b1);
        wr(A_STAT, 32'h1000);
        check_reg("R3 inactive level clears", A_STAT, 0);
        set_pin(13, 1'b1);
        wr(A_TYPE, 32'h3000);
        @(posedge clk); #1;
        check_reg("R3 active-high level sets", A_STAT, 32'h2000);
        wr(A_TYPE, 32'h0);
        wr(A_STAT, 32'h3000);
        check_reg("R3 back to edge mode", A_STAT, 0);
    endtask

    task automatic t_coincide();
        wr(A_RISE, 32'h100088);
        @(negedge clk);
        pins[20] = 1'b1;
        wr_en = 1'b1; wr_addr = A_STAT; wr_data = 32'h100000;
        @(posedge clk); #1;
        wr_en = 1'b0;
        check_reg("R6 event beats clear", A_STAT, 32'h100000);
        wr(A_STAT, 32'h100000);
        check_reg("R6 later clear works", A_STAT, 0);
    endtask

    task automatic t_wake();
        wr(A_WMSK, 32'h200000);
        wr(A_RISE, 32'h700088);
        set_pin(21, 1'b1);
        set_pin(22, 1'b1);
        check_reg("R7 wake only masked pin", A_WSTA, 32'h200000);
        check("R7 wake_out high", {31'd0, wake_out}, 1);
        check_reg("R7 irq status both pins", A_STAT, 32'h600000);
        wr(A_WSTA, 32'h200000);
        check("R7 wake_out cleared", {31'd0, wake_out}, 0);
        check_reg("R7 wake status cleared", A_WSTA, 0);
        check_reg("R7 irq status untouched", A_STAT, 32'h600000);
    endtask

    task automatic t_unmapped();
        wr(12'h200, 32'hFFFF_FFFF);
        check_reg("R9 unmapped reads 0", 12'h200, 0);
        wr(A_RISE + 12'd8, 32'hFFFF_FFFF);
        check_reg("R9 out-of-range word reads 0", A_RISE + 12'd8, 0);
        check_reg("R9 rise word0 unchanged", A_RISE, 32'h700088);
        check_reg("R9 rise word1 unchanged", A_RISE + 12'd4, 32'h100);
        check_reg("R9 misaligned reads 0", A_WMSK + 12'd2, 0);
        check_reg("R9 polarity readback", A_POL, 32'h1000);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        pins[3] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_rise();
        t_fall_both();
        t_mask();
        t_level();
        t_coincide();
        t_wake();
        t_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule